// File: doc/BRIEF.md
# Multicore Private Peripheral Window Decoder

This block is the address front end of a small multicore cluster's private peripheral window, an 8 KiB region. A single register-bus requester reaches it through a simple slave port. The snoop-control registers live inside the block. Every other access is decoded into one of several subordinate selects: interrupt CPU interfaces, per-core timers, per-core watchdogs and the interrupt distributor. The offset inside the subordinate is passed through, and the read data the subordinate returns comes back to the requester one cycle later. The CPU-interface and timer ranges both open with an alias slot that means "the requesting core". A core-ID input resolves that slot, so software on any core can use the same addresses for its own resources.

The block also builds the interrupt-controller input vector. External lines pass straight through to the low indices. Each core then owns a group of 32 private lines. Within its group, each core's timer and watchdog interrupts are placed on fixed private positions.

Top module: `mpriv_window_decoder`

## Requirements
- R1: An access is taken in any cycle with `req_valid` high. One cycle later `rsp_valid` is high together with the registered `rsp_rdata` and `rsp_err`. A cycle with no access gives `rsp_valid`=0 and `rsp_err`=0 one cycle later, and both are 0 after reset.
- R2: A write to window offset 0x000 stores only bit 0 of the write data. A read of 0x000 returns that bit in bit 0 and zero elsewhere. The stored bit resets to 0 and changes on no other access.
- R3: Reading offset 0x004 returns NUM_CORES-1 in bits [3:0] and a mask of NUM_CORES ones starting at bit 4. For two cores this is 0x31.
- R4: Offsets 0x008 and 0x00C read as zero without error. A write to 0x00C completes without error and changes nothing.
- R5: Any other offset below 0x100, and any write to 0x004 or 0x008, returns zero data and raises `rsp_err` for that single response. Such a write changes no state.
- R6: Offsets 0x100·(1+k) to 0x100·(1+k)+0xFF, for k from 0 to NUM_CORES, select a CPU interface. k=0 selects the interface of core `req_core`, and k≥1 selects core k-1. `sub_off` carries address bits [7:0], and the response returns that interface's read data.
- R7: Offsets 0x600+0x100·k+0x00 to +0x1F select the timer of the core chosen by the same k rule as R6. Offsets +0x20 to +0x3F select the watchdog of that core. `sub_off` carries address bits [4:0], and the response returns the selected read data.
- R8: Offsets 0x1000 to 0x1FFF select the distributor. `sub_off` carries address bits [11:0], and the response returns the distributor read data.
- R9: An alias slot used with `req_core` ≥ NUM_CORES, bytes 0x40 to 0xFF of a timer slot, and every offset outside the ranges of R2 to R8 assert no select. They return zero data with `rsp_err` high.
- R10: At most one subordinate select is high in any cycle. No select is high without `req_valid`.
- R11: `sub_wr` is high exactly when a write hits a subordinate select, and `sub_wdata` carries `req_wdata`. Snoop-control and unmapped writes leave `sub_wr` low.
- R12: `gic_irq_in[E-1:0]` equals `ext_irq`, with E = TOTAL_IRQS-32. For core i, `tmr_irq[i]` drives index E+32·i+29 and `wdog_irq[i]` drives index E+32·i+30. All other indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset inside the window |
| req_wdata | input | DW | Write data |
| req_core | input | ID_W | ID of the requesting core |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | DW | Registered read data |
| rsp_err | output | 1 | Bad-access flag for this response |
| sub_off | output | 12 | Offset inside the selected subordinate |
| sub_wr | output | 1 | Write strobe to the selected subordinate |
| sub_wdata | output | DW | Write data to subordinates |
| cpuif_sel | output | NUM_CORES | Per-core CPU interface select |
| cpuif_rdata | input | NUM_CORES·DW | Per-core CPU interface read data |
| tmr_sel | output | NUM_CORES | Per-core timer select |
| tmr_rdata | input | NUM_CORES·DW | Per-core timer read data |
| wdog_sel | output | NUM_CORES | Per-core watchdog select |
| wdog_rdata | input | NUM_CORES·DW | Per-core watchdog read data |
| dist_sel | output | 1 | Distributor select |
| dist_rdata | input | DW | Distributor read data |
| ext_irq | input | TOTAL_IRQS-32 | External interrupt lines |
| tmr_irq | input | NUM_CORES | Per-core timer interrupts |
| wdog_irq | input | NUM_CORES | Per-core watchdog interrupts |
| gic_irq_in | output | TOTAL_IRQS-32+32·NUM_CORES | Interrupt controller input vector |

## Verification
The hardest case to reach is the alias slot resolved against a core ID that does not exist, crossed with every sub-range of the timer and watchdog slots. A directed test would touch only a few of these combinations. The stimulus therefore sweeps every word offset of the window under every value of `req_core`, using two cores and a two-bit ID, so IDs 2 and 3 are out of range. An arithmetic model in the bench predicts each select, offset, read-data source and error. The control bit's hold behaviour is covered by interleaving writes to the read-only, ignored and unmapped offsets between reads of the control register.

// File: rtl/mpriv_pkg.sv
package mpriv_pkg;

  localparam int WIN_AW     = 13;
  localparam int SUB_AW     = 12;
  localparam int PRIV_LINES = 32;
  localparam int PPI_TIMER  = 29;
  localparam int PPI_WDOG   = 30;
  localparam int CORE_W     = 2;

  localparam logic [3:0] CPUIF_PAGE0 = 4'h1;
  localparam logic [3:0] TW_PAGE0    = 4'h6;
  localparam logic [7:0] TW_SPAN     = 8'h20;
  localparam logic [7:0] TW_LIMIT    = 8'h40;

  localparam logic [7:0] SCU_CTRL = 8'h00;
  localparam logic [7:0] SCU_CFG  = 8'h04;
  localparam logic [7:0] SCU_STAT = 8'h08;
  localparam logic [7:0] SCU_INV  = 8'h0C;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SCU,
    TGT_CPUIF,
    TGT_TIMER,
    TGT_WDOG,
    TGT_DIST
  } tgt_e;

  typedef struct packed {
    tgt_e               tgt;
    logic [CORE_W-1:0]  core;
    logic [SUB_AW-1:0]  off;
  } dec_t;

  function automatic logic [31:0] cfg_word(input int n);
    logic [31:0] mask;
    mask = ((32'd1 << n) - 32'd1) << 4;
    return mask | 32'(n - 1);
  endfunction

endpackage

// File: rtl/mpriv_addr_decode.sv
module mpriv_addr_decode
  import mpriv_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ID_W      = 2
) (
  input  logic [WIN_AW-1:0] addr,
  input  logic [ID_W-1:0]   core_id,
  output dec_t              dec
);

  localparam logic [3:0] LAST_K = 4'(NUM_CORES);

  logic [3:0] page;
  logic [7:0] low;
  logic [3:0] cpu_k;
  logic [3:0] tw_k;
  logic       in_cpu;
  logic       in_tw;
  logic [3:0] slot_k;
  logic       own_ok;
  logic       core_ok;
  logic [CORE_W-1:0] core_sel;

  always_comb begin
    page   = addr[11:8];
    low    = addr[7:0];
    cpu_k  = page - CPUIF_PAGE0;
    tw_k   = page - TW_PAGE0;
    in_cpu = !addr[WIN_AW-1] && (page >= CPUIF_PAGE0) && (cpu_k <= LAST_K);
    in_tw  = !addr[WIN_AW-1] && (page >= TW_PAGE0) && (tw_k <= LAST_K) && (low < TW_LIMIT);
    slot_k = in_cpu ? cpu_k : tw_k;
    own_ok = (32'(core_id) < NUM_CORES);
    core_ok  = (slot_k != 4'd0) || own_ok;
    core_sel = (slot_k == 4'd0) ? CORE_W'(core_id) : CORE_W'(slot_k - 4'd1);
  end

  always_comb begin
    dec      = '0;
    dec.tgt  = TGT_NONE;
    if (addr[WIN_AW-1]) begin
      dec.tgt = TGT_DIST;
      dec.off = addr[SUB_AW-1:0];
    end else if (page == 4'h0) begin
      dec.tgt = TGT_SCU;
      dec.off = {4'h0, low};
    end else if (in_cpu && core_ok) begin
      dec.tgt  = TGT_CPUIF;
      dec.core = core_sel;
      dec.off  = {4'h0, low};
    end else if (in_tw && core_ok) begin
      dec.tgt  = (low < TW_SPAN) ? TGT_TIMER : TGT_WDOG;
      dec.core = core_sel;
      dec.off  = {7'h00, low[4:0]};
    end
  end

endmodule

// File: rtl/mpriv_scu_regs.sv
module mpriv_scu_regs
  import mpriv_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          wr,
  input  logic [7:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bad
);

  localparam logic [DW-1:0] CFG_VAL = DW'(cfg_word(NUM_CORES));

  logic ctrl_q;
  logic ctrl_d;
  logic ctrl_en;
  logic bad_raw;

  always_comb begin
    rdata   = '0;
    bad_raw = 1'b0;
    ctrl_en = 1'b0;
    ctrl_d  = ctrl_q;
    case (off)
      SCU_CTRL: begin
        rdata = DW'(ctrl_q);
        if (acc && wr) begin
          ctrl_en = 1'b1;
          ctrl_d  = wdata[0];
        end
      end
      SCU_CFG:  begin
        rdata   = CFG_VAL;
        bad_raw = wr;
      end
      SCU_STAT: bad_raw = wr;
      SCU_INV:  bad_raw = 1'b0;
      default:  bad_raw = 1'b1;
    endcase
    bad = acc && bad_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  // R2: the control bit moves only on a write to its own offset
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && wr && off == SCU_CTRL) |=> $stable(ctrl_q));

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr && off == SCU_CTRL) |=> (ctrl_q == $past(wdata[0])));

endmodule

// File: rtl/mpriv_sub_port.sv
module mpriv_sub_port
  import mpriv_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int DW        = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  dec_t                   dec,
  input  logic [NUM_CORES*DW-1:0] cpuif_rdata,
  input  logic [NUM_CORES*DW-1:0] tmr_rdata,
  input  logic [NUM_CORES*DW-1:0] wdog_rdata,
  input  logic [DW-1:0]          dist_rdata,
  output logic [NUM_CORES-1:0]   cpuif_sel,
  output logic [NUM_CORES-1:0]   tmr_sel,
  output logic [NUM_CORES-1:0]   wdog_sel,
  output logic                   dist_sel,
  output logic [DW-1:0]          sub_rdata
);

  localparam int SEL_W = 3 * NUM_CORES + 1;

  genvar c;
  generate
    for (c = 0; c < NUM_CORES; c++) begin : g_sel
      logic hit_core;
      assign hit_core     = req_valid && (32'(dec.core) == c);
      assign cpuif_sel[c] = hit_core && (dec.tgt == TGT_CPUIF);
      assign tmr_sel[c]   = hit_core && (dec.tgt == TGT_TIMER);
      assign wdog_sel[c]  = hit_core && (dec.tgt == TGT_WDOG);
    end
  endgenerate

  assign dist_sel = req_valid && (dec.tgt == TGT_DIST);

  logic [DW-1:0] cpu_pick;
  logic [DW-1:0] tmr_pick;
  logic [DW-1:0] wdog_pick;

  always_comb begin
    cpu_pick  = '0;
    tmr_pick  = '0;
    wdog_pick = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (32'(dec.core) == k) begin
        cpu_pick  = cpuif_rdata[k*DW +: DW];
        tmr_pick  = tmr_rdata[k*DW +: DW];
        wdog_pick = wdog_rdata[k*DW +: DW];
      end
    end
    case (dec.tgt)
      TGT_CPUIF: sub_rdata = cpu_pick;
      TGT_TIMER: sub_rdata = tmr_pick;
      TGT_WDOG:  sub_rdata = wdog_pick;
      TGT_DIST:  sub_rdata = dist_rdata;
      default:   sub_rdata = '0;
    endcase
  end

  logic [SEL_W-1:0] all_sel;
  assign all_sel = {cpuif_sel, tmr_sel, wdog_sel, dist_sel};

  // R10: one subordinate at a time, none while idle
  assert_one_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_sel));

  assert_idle_nosel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (all_sel == '0));

endmodule

// File: rtl/mpriv_irq_route.sv
module mpriv_irq_route
  import mpriv_pkg::*;
#(
  parameter int NUM_CORES  = 1,
  parameter int TOTAL_IRQS = 64
) (
  input  logic [TOTAL_IRQS-PRIV_LINES-1:0]                      ext_irq,
  input  logic [NUM_CORES-1:0]                                  tmr_irq,
  input  logic [NUM_CORES-1:0]                                  wdog_irq,
  output logic [TOTAL_IRQS-PRIV_LINES+PRIV_LINES*NUM_CORES-1:0] gic_irq_in
);

  localparam int EXT_LINES = TOTAL_IRQS - PRIV_LINES;

  always_comb begin
    gic_irq_in = '0;
    gic_irq_in[EXT_LINES-1:0] = ext_irq;
    for (int c = 0; c < NUM_CORES; c++) begin
      gic_irq_in[EXT_LINES + PRIV_LINES*c + PPI_TIMER] = tmr_irq[c];
      gic_irq_in[EXT_LINES + PRIV_LINES*c + PPI_WDOG]  = wdog_irq[c];
    end
  end

endmodule

// File: rtl/mpriv_window_decoder.sv
module mpriv_window_decoder
  import mpriv_pkg::*;
#(
  parameter int NUM_CORES  = 1,
  parameter int TOTAL_IRQS = 64,
  parameter int DW         = 32,
  parameter int ID_W       = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic [12:0]                          req_addr,
  input  logic [DW-1:0]                        req_wdata,
  input  logic [ID_W-1:0]                      req_core,
  output logic                                 rsp_valid,
  output logic [DW-1:0]                        rsp_rdata,
  output logic                                 rsp_err,
  output logic [11:0]                          sub_off,
  output logic                                 sub_wr,
  output logic [DW-1:0]                        sub_wdata,
  output logic [NUM_CORES-1:0]                 cpuif_sel,
  input  logic [NUM_CORES*DW-1:0]              cpuif_rdata,
  output logic [NUM_CORES-1:0]                 tmr_sel,
  input  logic [NUM_CORES*DW-1:0]              tmr_rdata,
  output logic [NUM_CORES-1:0]                 wdog_sel,
  input  logic [NUM_CORES*DW-1:0]              wdog_rdata,
  output logic                                 dist_sel,
  input  logic [DW-1:0]                        dist_rdata,
  input  logic [TOTAL_IRQS-33:0]               ext_irq,
  input  logic [NUM_CORES-1:0]                 tmr_irq,
  input  logic [NUM_CORES-1:0]                 wdog_irq,
  output logic [TOTAL_IRQS-33+32*NUM_CORES:0]  gic_irq_in
);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  dec_t dec;

  mpriv_addr_decode #(
    .NUM_CORES (NUM_CORES),
    .ID_W      (ID_W)
  ) u_decode (
    .addr    (req_addr),
    .core_id (req_core),
    .dec     (dec)
  );

  logic          scu_acc;
  logic [DW-1:0] scu_rdata;
  logic          scu_bad;

  assign scu_acc = req_valid && (dec.tgt == TGT_SCU);

  mpriv_scu_regs #(
    .NUM_CORES (NUM_CORES),
    .DW        (DW)
  ) u_scu (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .acc   (scu_acc),
    .wr    (req_write),
    .off   (dec.off[7:0]),
    .wdata (req_wdata),
    .rdata (scu_rdata),
    .bad   (scu_bad)
  );

  logic [DW-1:0] sub_rdata;

  mpriv_sub_port #(
    .NUM_CORES (NUM_CORES),
    .DW        (DW)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .dec         (dec),
    .cpuif_rdata (cpuif_rdata),
    .tmr_rdata   (tmr_rdata),
    .wdog_rdata  (wdog_rdata),
    .dist_rdata  (dist_rdata),
    .cpuif_sel   (cpuif_sel),
    .tmr_sel     (tmr_sel),
    .wdog_sel    (wdog_sel),
    .dist_sel    (dist_sel),
    .sub_rdata   (sub_rdata)
  );

  mpriv_irq_route #(
    .NUM_CORES  (NUM_CORES),
    .TOTAL_IRQS (TOTAL_IRQS)
  ) u_irq (
    .ext_irq    (ext_irq),
    .tmr_irq    (tmr_irq),
    .wdog_irq   (wdog_irq),
    .gic_irq_in (gic_irq_in)
  );

  logic sub_hit;
  assign sub_hit   = (dec.tgt != TGT_NONE) && (dec.tgt != TGT_SCU);
  assign sub_off   = dec.off;
  assign sub_wdata = req_wdata;
  assign sub_wr    = req_valid && req_write && sub_hit;

  // response stage
  logic          rsp_valid_q, rsp_valid_d;
  logic          rsp_err_q,   rsp_err_d;
  logic [DW-1:0] rsp_rdata_q, rsp_rdata_d;
  logic          rsp_en;

  always_comb begin
    rsp_en      = req_valid || rsp_valid_q;
    rsp_valid_d = req_valid;
    rsp_err_d   = req_valid && ((dec.tgt == TGT_NONE) || scu_bad);
    rsp_rdata_d = '0;
    if (req_valid && !rsp_err_d) begin
      rsp_rdata_d = (dec.tgt == TGT_SCU) ? scu_rdata : sub_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (rsp_en) begin
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

  // R1: one response per access, exactly one cycle later
  assert_rsp_follow_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!rsp_valid && !rsp_err));

  // R5 / R9: an error response carries no data
  assert_err_nodata_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> (rsp_rdata == '0));

  // R11: the subordinate write strobe only for a write with a live select
  assert_subwr_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sub_wr |-> (req_write && (|{cpuif_sel, tmr_sel, wdog_sel, dist_sel})));

endmodule

// File: tb/mpriv_window_decoder_tb.sv
module mpriv_window_decoder_tb;

  localparam int NC   = 2;
  localparam int TI   = 64;
  localparam int DW   = 32;
  localparam int IDW  = 2;
  localparam int EXT  = TI - 32;
  localparam int OUTW = EXT + 32 * NC;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [12:0]       req_addr;
  logic [DW-1:0]     req_wdata;
  logic [IDW-1:0]    req_core;
  logic              rsp_valid, rsp_err;
  logic [DW-1:0]     rsp_rdata;
  logic [11:0]       sub_off;
  logic              sub_wr;
  logic [DW-1:0]     sub_wdata;
  logic [NC-1:0]     cpuif_sel, tmr_sel, wdog_sel;
  logic              dist_sel;
  logic [NC*DW-1:0]  cpuif_rdata, tmr_rdata, wdog_rdata;
  logic [DW-1:0]     dist_rdata;
  logic [EXT-1:0]    ext_irq;
  logic [NC-1:0]     tmr_irq, wdog_irq;
  logic [OUTW-1:0]   gic_irq_in;

  always #10 clk = ~clk;

  mpriv_window_decoder #(
    .NUM_CORES (NC), .TOTAL_IRQS (TI), .DW (DW), .ID_W (IDW)
  ) u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
    .req_wdata (req_wdata), .req_core (req_core),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .rsp_err (rsp_err),
    .sub_off (sub_off), .sub_wr (sub_wr), .sub_wdata (sub_wdata),
    .cpuif_sel (cpuif_sel), .cpuif_rdata (cpuif_rdata),
    .tmr_sel (tmr_sel), .tmr_rdata (tmr_rdata),
    .wdog_sel (wdog_sel), .wdog_rdata (wdog_rdata),
    .dist_sel (dist_sel), .dist_rdata (dist_rdata),
    .ext_irq (ext_irq), .tmr_irq (tmr_irq), .wdog_irq (wdog_irq),
    .gic_irq_in (gic_irq_in)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic ctrl_model;

  function automatic logic [DW-1:0] cpu_val(int c);  return 32'h1100_00A0 + c; endfunction
  function automatic logic [DW-1:0] tmr_val(int c);  return 32'h2200_00B0 + c; endfunction
  function automatic logic [DW-1:0] wdog_val(int c); return 32'h3300_00C0 + c; endfunction

  // expected values for one access
  logic [NC-1:0] e_cpu, e_tmr, e_wdog;
  logic          e_dist, e_err;
  logic [11:0]   e_off;
  logic [DW-1:0] e_data;
  string         e_tag;

  task automatic model(input logic [12:0] a, input int id, input logic wr);
    int page, low, k, core;
    e_cpu = '0; e_tmr = '0; e_wdog = '0; e_dist = 1'b0;
    e_off = '0; e_data = '0; e_err = 1'b1; e_tag = "R9";
    page = int'(a[11:8]);
    low  = int'(a[7:0]);
    if (a[12]) begin
      e_dist = 1'b1; e_off = a[11:0]; e_data = 32'h4400_00D0; e_err = 1'b0; e_tag = "R8";
    end else if (page == 0) begin
      case (low)
        0:  begin e_err = 1'b0; e_data = 32'(ctrl_model); e_tag = "R2"; end
        4:  begin e_err = wr; e_data = wr ? 32'h0 : 32'h31; e_tag = wr ? "R5" : "R3"; end
        8:  begin e_err = wr; e_tag = wr ? "R5" : "R4"; end
        12: begin e_err = 1'b0; e_tag = "R4"; end
        default: begin e_err = 1'b1; e_tag = "R5"; end
      endcase
    end else if (page >= 1 && page <= 1 + NC) begin
      k = page - 1;
      core = (k == 0) ? id : k - 1;
      if (core < NC) begin
        e_cpu[core] = 1'b1; e_off = 12'(low); e_data = cpu_val(core);
        e_err = 1'b0; e_tag = "R6";
      end
    end else if (page >= 6 && page <= 6 + NC && low < 'h40) begin
      k = page - 6;
      core = (k == 0) ? id : k - 1;
      if (core < NC) begin
        e_off = 12'(low % 32); e_err = 1'b0; e_tag = "R7";
        if (low < 'h20) begin e_tmr[core] = 1'b1; e_data = tmr_val(core); end
        else begin e_wdog[core] = 1'b1; e_data = wdog_val(core); end
      end
    end
  endtask

  task automatic access(input logic [12:0] a, input int id, input logic wr,
                        input logic [DW-1:0] wd);
    logic any;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    req_core = IDW'(id);
    model(a, id, wr);
    any = (|e_cpu) | (|e_tmr) | (|e_wdog) | e_dist;
    #1;
    checks++;
    if (cpuif_sel !== e_cpu || tmr_sel !== e_tmr || wdog_sel !== e_wdog ||
        dist_sel !== e_dist || (any && sub_off !== e_off) ||
        sub_wr !== (wr & any) || (wr && any && sub_wdata !== wd)) begin
      errors++;
      $display("FAIL %s/R10/R11 addr=%h core=%0d wr=%0b sel got %b_%b_%b_%b off=%h wr=%b exp %b_%b_%b_%b off=%h wr=%b",
               e_tag, a, id, wr, cpuif_sel, tmr_sel, wdog_sel, dist_sel, sub_off, sub_wr,
               e_cpu, e_tmr, e_wdog, e_dist, e_off, wr & any);
    end
    @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_err !== e_err || rsp_rdata !== e_data) begin
      errors++;
      $display("FAIL %s/R1 addr=%h core=%0d wr=%0b rsp got v=%b err=%b data=%h exp v=1 err=%b data=%h",
               e_tag, a, id, wr, rsp_valid, rsp_err, rsp_rdata, e_err, e_data);
    end
    if (wr && a == 13'h000) ctrl_model = wd[0];
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic irq_check(input logic [EXT-1:0] e, input logic [NC-1:0] t,
                           input logic [NC-1:0] w);
    logic [OUTW-1:0] exp_v;
    ext_irq = e; tmr_irq = t; wdog_irq = w;
    exp_v = '0;
    exp_v[EXT-1:0] = e;
    for (int c = 0; c < NC; c++) begin
      exp_v[EXT + 32*c + 29] = t[c];
      exp_v[EXT + 32*c + 30] = w[c];
    end
    #1;
    checks++;
    if (gic_irq_in !== exp_v) begin
      errors++;
      $display("FAIL R12 irq got %h exp %h", gic_irq_in, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      cpuif_rdata[c*DW +: DW] = cpu_val(c);
      tmr_rdata[c*DW +: DW]   = tmr_val(c);
      wdog_rdata[c*DW +: DW]  = wdog_val(c);
    end
    dist_rdata = 32'h4400_00D0;
    ctrl_model = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_core = '0;
    ext_irq = '0; tmr_irq = '0; wdog_irq = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state got v=%b err=%b exp v=0 err=0", rsp_valid, rsp_err);
    end

    // R2 reset value of the control bit, R3 config
    access(13'h000, 0, 1'b0, '0);
    access(13'h004, 0, 1'b0, '0);

    // full sweep of word offsets under every core ID
    for (int id = 0; id < (1 << IDW); id++) begin
      for (int a = 0; a < 'h2000; a += 4) begin
        access(13'(a), id, 1'b0, '0);
      end
    end
    // R5 misaligned snoop offsets, R7 unaligned timer bytes
    access(13'h001, 0, 1'b0, '0);
    access(13'h0FE, 1, 1'b0, '0);
    access(13'h63F, 1, 1'b0, '0);
    access(13'h640, 0, 1'b0, '0);

    // R1 idle cycle gives no response
    go_idle();
    @(posedge clk); #1;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle got v=%b err=%b exp v=0 err=0", rsp_valid, rsp_err);
    end

    // R2 control bit keeps only bit 0; R4/R5 writes with no effect
    access(13'h000, 0, 1'b1, 32'hFFFF_FFFE);
    access(13'h000, 0, 1'b0, '0);
    access(13'h000, 1, 1'b1, 32'h0000_0003);
    access(13'h000, 0, 1'b0, '0);
    access(13'h00C, 0, 1'b1, 32'h0000_0000);
    access(13'h000, 0, 1'b0, '0);
    access(13'h004, 0, 1'b1, 32'h0000_0000);
    access(13'h004, 0, 1'b0, '0);
    access(13'h008, 0, 1'b1, 32'h0000_0000);
    access(13'h010, 0, 1'b1, 32'h0000_0000);
    access(13'h300, 0, 1'b1, 32'h0000_0000);
    access(13'h000, 0, 1'b0, '0);

    // R11 writes to subordinates
    access(13'h620, 1, 1'b1, 32'hCAFE_0001);
    access(13'h104, 0, 1'b1, 32'hCAFE_0002);
    access(13'h204, 0, 1'b1, 32'hCAFE_0003);
    access(13'h1ABC, 3, 1'b1, 32'hCAFE_0004);
    access(13'h704, 0, 1'b1, 32'hCAFE_0005);
    access(13'h104, 2, 1'b1, 32'hCAFE_0006);
    go_idle();

    // R12 interrupt wiring
    for (int v = 0; v < 16; v++) begin
      irq_check('0, NC'(v), NC'(v >> 2));
    end
    for (int b = 0; b < EXT; b++) begin
      irq_check(EXT'(1) << b, '0, '0);
    end
    irq_check('1, '1, '1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule